// File: doc/BRIEF.md
# Multichannel ADC Conversion Sequencer

This block runs conversion sequences for one 8-bit successive-approximation converter that sits behind an eight-way analog multiplexer. Software programs it through a small register bus. A control register holds a power enable and a flag-clear mode. A mode register holds the sequence length, the scan and group options and a channel field. Writing the mode register starts a sequence. The block then chooses the multiplexer input, waits through a fixed sample window and searches for the code bit by bit, most significant bit first. For each trial it presents a DAC code and reads back one comparator bit.

Each finished conversion lands in the result register that has the same index as its place in the sequence. A sequence has four or eight conversions. Status holds a flag per result register, a sequence-complete flag and the index of the conversion now running. Flags are cleared either by the next mode write or, in fast-clear mode, by reading the result. The multiplexer, DAC and comparator are outside the block.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, every register reads 0. Power is off, no flags are set, the status counter is 0 and `dac_code` is 0.
- R2: A mode write made while power is off starts nothing. After power is enabled, no trial code is driven until SETTLE_CYC cycles have passed.
- R3: Each conversion drives trial codes MSB first. A bit is kept when `cmp_hi` is 1 for its trial, so with a comparator that reports (input >= code), the stored result equals the selected input's 8-bit value.
- R4: With mode bit 0 = 0, a sequence makes four conversions into results 0..3. Results 4..7 and their flags are not touched. Flag byte bits 3:0 are set.
- R5: With mode bit 0 = 1, a sequence makes eight conversions into results 0..7 and sets all eight flags.
- R6: Channel choice for conversion k: with mode bit 2 = 0, every conversion uses mode bits 6:4. With bit 2 = 1 and eight conversions, it uses channel k. With bit 2 = 1 and four conversions, it uses {mode bit 6, k[1:0]}. Mode bit 7 does not affect channel choice.
- R7: With mode bit 1 = 1, sequences repeat without end. The counter wraps to 0 after the last conversion and the sequence-complete flag sets at the end of each pass.
- R8: With ctrl bit 1 = 0, a mode write clears all flags and reading a result leaves the flags unchanged.
- R9: With ctrl bit 1 = 1, reading result register N (address 8+N) clears flag N and the sequence-complete flag.
- R10: A mode write during a running sequence aborts it. The status counter returns to 0 and the new sequence refills results starting from conversion 0.
- R11: Writing ctrl bit 0 = 0 stops all activity from the next cycle. `dac_code` stays 0 and no result changes after that.
- R12: Register map: address 0 is ctrl {bit1 fast-clear, bit0 power}. Address 1 is mode, which reads back with bit 3 as 0. Address 2 is status {bit7 sequence complete, bits 2:0 counter}. Address 3 is the flag byte. Addresses 8..15 are the results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (used for read-clear) |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from address |
| cmp_hi | input | 1 | Comparator: analog input >= DAC code |
| mux_sel | output | 3 | Analog multiplexer channel select |
| dac_code | output | 8 | Trial code during a search step, 0 otherwise |

## Verification
The bench aims at the four-conversion group mapping. A design that ignores mode bit 6 or lets writes spill into results 4..7 would return the wrong inputs or overwrite older results. A second mode write made part way through a pass, with the inputs inverted in between, shows whether a design resumes instead of restarting: results 0 and 1 would keep stale values. Read-clear is exercised in both flag modes, because clearing in the wrong mode silently loses or keeps flags. The bench also checks the settle window and power-off, where a design that jumps the delay or keeps stepping would drive nonzero trial codes.

// File: rtl/adc_seq_pkg.sv
// Package adc_seq_pkg: shared widths, the register address map, the SAR phase
// type and the mode-register layout for the conversion sequencer.
package adc_seq_pkg;
    localparam int RES_W   = 8;
    localparam int NUM_RES = 8;
    localparam int IDX_W   = $clog2(NUM_RES);
    localparam int ADDR_W  = 4;
    localparam int DATA_W  = 8;

    localparam logic [ADDR_W-1:0] A_CTRL = 4'h0;
    localparam logic [ADDR_W-1:0] A_MODE = 4'h1;
    localparam logic [ADDR_W-1:0] A_STAT = 4'h2;
    localparam logic [ADDR_W-1:0] A_FLAG = 4'h3;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SAMPLE = 2'd1,
        PH_STEP   = 2'd2
    } sar_phase_t;

    // Mode register as stored (write bit 3 is dropped).
    typedef struct packed {
        logic [3:0] chan;
        logic       multi;
        logic       scan;
        logic       len8;
    } mode_t;
endpackage

// File: rtl/adc_sar_core.sv
// adc_sar_core: one conversion. On start it holds a sample window of SAMPLE_CYC
// cycles, then it runs RES_W search steps from MSB to LSB, one per cycle. It
// assumes the comparator answers within the same cycle as the trial code.
// abort_i returns it to idle at once. done_o pulses for one cycle, with the
// result held in result_o.
module adc_sar_core #(
    parameter int RES_W      = 8,
    parameter int SAMPLE_CYC = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             abort_i,
    input  logic             start_i,
    input  logic             cmp_hi_i,
    output logic [RES_W-1:0] dac_code_o,
    output logic             done_o,
    output logic [RES_W-1:0] result_o
);
    import adc_seq_pkg::*;

    localparam int SCW = $clog2(SAMPLE_CYC + 1);
    localparam int BW  = (RES_W > 1) ? $clog2(RES_W) : 1;

    sar_phase_t       phase;
    logic [SCW-1:0]   samp_cnt;
    logic [BW-1:0]    bit_idx;
    logic [RES_W-1:0] acc;
    logic [RES_W-1:0] trial;
    logic [RES_W-1:0] acc_next;

    // Trial code = bits kept so far plus the bit under test.
    always_comb begin
        trial    = acc | (RES_W'(1) << bit_idx);
        acc_next = cmp_hi_i ? trial : acc;
    end

    // DAC sees a code only while a search step is active.
    assign dac_code_o = (phase == PH_STEP) ? trial : '0;

    // Phase sequencing, sample count and bit search.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_IDLE;
            samp_cnt <= '0;
            bit_idx  <= '0;
            acc      <= '0;
            done_o   <= 1'b0;
            result_o <= '0;
        end else if (abort_i) begin
            phase  <= PH_IDLE;
            done_o <= 1'b0;
        end else begin
            done_o <= 1'b0;
            case (phase)
                PH_IDLE: begin
                    if (start_i) begin
                        phase    <= PH_SAMPLE;
                        samp_cnt <= '0;
                        acc      <= '0;
                    end
                end
                PH_SAMPLE: begin
                    if (samp_cnt == SCW'(SAMPLE_CYC - 1)) begin
                        phase   <= PH_STEP;
                        bit_idx <= BW'(RES_W - 1);
                    end else begin
                        samp_cnt <= samp_cnt + SCW'(1);
                    end
                end
                PH_STEP: begin
                    acc <= acc_next;
                    if (bit_idx == '0) begin
                        done_o   <= 1'b1;
                        result_o <= acc_next;
                        phase    <= PH_IDLE;
                    end else begin
                        bit_idx <= bit_idx - BW'(1);
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/adc_seq_fsm.sv
// adc_seq_fsm: sequence control. It times the power settle window, keeps the
// index of the conversion in progress, launches each conversion, maps the index
// to a mux channel and marks the end of each pass. It assumes mode fields are
// registered and that they change only at a mode write. That write (or a
// power-off write) aborts the core in the same cycle.
module adc_seq_fsm #(
    parameter int SETTLE_CYC = 64,
    parameter int IDX_W      = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwr_en_i,
    input  logic             pwr_off_wr_i,
    input  logic             mode_wr_i,
    input  logic             len8_i,
    input  logic             scan_i,
    input  logic             multi_i,
    input  logic [2:0]       chan_i,
    input  logic             core_done_i,
    output logic             core_start_o,
    output logic             kill_o,
    output logic [IDX_W-1:0] idx_o,
    output logic [2:0]       mux_sel_o,
    output logic             res_we_o,
    output logic             seq_end_o,
    output logic             settled_o
);
    localparam int STW = $clog2(SETTLE_CYC + 1);

    logic [STW-1:0]   settle_cnt;
    logic             active;
    logic             pend;
    logic [IDX_W-1:0] last_idx;

    assign kill_o       = mode_wr_i | pwr_off_wr_i;
    assign last_idx     = len8_i ? IDX_W'(7) : IDX_W'(3);
    assign core_start_o = active & pend & settled_o & ~kill_o;
    assign res_we_o     = core_done_i & active & ~kill_o;
    assign seq_end_o    = res_we_o & (idx_o == last_idx);

    // Channel for the current conversion index.
    always_comb begin
        if (!multi_i)    mux_sel_o = chan_i;
        else if (len8_i) mux_sel_o = 3'(idx_o);
        else             mux_sel_o = {chan_i[2], idx_o[1:0]};
    end

    // Power settle counter: restarts whenever power is off.
    always_ff @(posedge clk) begin
        if (!rst_n || !pwr_en_i || pwr_off_wr_i) begin
            settle_cnt <= '0;
            settled_o  <= 1'b0;
        end else if (!settled_o) begin
            if (settle_cnt == STW'(SETTLE_CYC - 1)) settled_o <= 1'b1;
            else settle_cnt <= settle_cnt + STW'(1);
        end
    end

    // Sequence state: run flag, pending launch and conversion index.
    always_ff @(posedge clk) begin
        if (!rst_n || pwr_off_wr_i) begin
            active <= 1'b0;
            pend   <= 1'b0;
            idx_o  <= '0;
        end else if (mode_wr_i) begin
            idx_o  <= '0;
            active <= pwr_en_i;
            pend   <= pwr_en_i;
        end else if (core_start_o) begin
            pend <= 1'b0;
        end else if (res_we_o) begin
            if (idx_o == last_idx) begin
                idx_o  <= '0;
                active <= scan_i;
                pend   <= scan_i;
            end else begin
                idx_o <= idx_o + IDX_W'(1);
                pend  <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/adc_result_bank.sv
// adc_result_bank: result storage and flags. It holds NUM_RES result registers,
// one complete flag per register and the sequence-complete flag. A mode write
// clears all flags. A result write sets its flag. A fast-clear read clears the
// flag of the register read and the sequence flag. A set wins over a read-clear
// in the same cycle.
module adc_result_bank #(
    parameter int RES_W   = 8,
    parameter int NUM_RES = 8
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            clr_all_i,
    input  logic                            we_i,
    input  logic [$clog2(NUM_RES)-1:0]      wr_idx_i,
    input  logic [RES_W-1:0]                wr_data_i,
    input  logic                            seq_end_i,
    input  logic                            rd_clr_i,
    input  logic [$clog2(NUM_RES)-1:0]      rd_idx_i,
    output logic [NUM_RES-1:0][RES_W-1:0]   res_o,
    output logic [NUM_RES-1:0]              ccf_o,
    output logic                            seq_done_o
);
    localparam int IW = $clog2(NUM_RES);

    for (genvar g = 0; g < NUM_RES; g++) begin : g_slot
        // Result register g: loads on its own write.
        always_ff @(posedge clk) begin
            if (!rst_n) res_o[g] <= '0;
            else if (we_i && wr_idx_i == IW'(g)) res_o[g] <= wr_data_i;
        end

        // Complete flag g: clear-all, set on write, clear on fast read.
        always_ff @(posedge clk) begin
            if (!rst_n || clr_all_i) ccf_o[g] <= 1'b0;
            else if (we_i && wr_idx_i == IW'(g)) ccf_o[g] <= 1'b1;
            else if (rd_clr_i && rd_idx_i == IW'(g)) ccf_o[g] <= 1'b0;
        end
    end

    // Sequence-complete flag.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_all_i) seq_done_o <= 1'b0;
        else if (seq_end_i) seq_done_o <= 1'b1;
        else if (rd_clr_i) seq_done_o <= 1'b0;
    end
endmodule

// File: rtl/adc_seq_ctrl.sv
// adc_seq_ctrl: top of the conversion sequencer. It decodes the register bus,
// holds the ctrl and mode registers, and joins the sequence control, the SAR
// core and the result bank. It assumes one bus access per cycle; read data is
// combinational from the address.
module adc_seq_ctrl #(
    parameter int SAMPLE_CYC = 4,
    parameter int SETTLE_CYC = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic [3:0] bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       cmp_hi,
    output logic [2:0] mux_sel,
    output logic [7:0] dac_code
);
    import adc_seq_pkg::*;

    logic                          pwr_en_q;
    logic                          fast_clr_q;
    mode_t                         mode_q;
    logic                          ctrl_wr, mode_wr, pwr_off_wr, rd_clr;
    logic                          core_start, core_kill, core_done;
    logic [RES_W-1:0]              core_result;
    logic [IDX_W-1:0]              seq_idx;
    logic                          res_we, seq_end, settled;
    logic [NUM_RES-1:0][RES_W-1:0] res;
    logic [NUM_RES-1:0]            ccf;
    logic                          seq_done;

    assign ctrl_wr    = bus_wr && (bus_addr == A_CTRL);
    assign mode_wr    = bus_wr && (bus_addr == A_MODE);
    assign pwr_off_wr = ctrl_wr && !bus_wdata[0];
    assign rd_clr     = bus_rd && bus_addr[3] && fast_clr_q;

    // Ctrl and mode registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pwr_en_q   <= 1'b0;
            fast_clr_q <= 1'b0;
            mode_q     <= '0;
        end else begin
            if (ctrl_wr) begin
                pwr_en_q   <= bus_wdata[0];
                fast_clr_q <= bus_wdata[1];
            end
            if (mode_wr) mode_q <= {bus_wdata[7:4], bus_wdata[2:0]};
        end
    end

    adc_seq_fsm #(.SETTLE_CYC(SETTLE_CYC), .IDX_W(IDX_W)) fsm_i (
        .clk(clk), .rst_n(rst_n),
        .pwr_en_i(pwr_en_q), .pwr_off_wr_i(pwr_off_wr), .mode_wr_i(mode_wr),
        .len8_i(mode_q.len8), .scan_i(mode_q.scan), .multi_i(mode_q.multi),
        .chan_i(mode_q.chan[2:0]), .core_done_i(core_done),
        .core_start_o(core_start), .kill_o(core_kill), .idx_o(seq_idx),
        .mux_sel_o(mux_sel), .res_we_o(res_we), .seq_end_o(seq_end),
        .settled_o(settled)
    );

    adc_sar_core #(.RES_W(RES_W), .SAMPLE_CYC(SAMPLE_CYC)) core_i (
        .clk(clk), .rst_n(rst_n), .abort_i(core_kill), .start_i(core_start),
        .cmp_hi_i(cmp_hi), .dac_code_o(dac_code), .done_o(core_done),
        .result_o(core_result)
    );

    adc_result_bank #(.RES_W(RES_W), .NUM_RES(NUM_RES)) bank_i (
        .clk(clk), .rst_n(rst_n), .clr_all_i(mode_wr), .we_i(res_we),
        .wr_idx_i(seq_idx), .wr_data_i(core_result), .seq_end_i(seq_end),
        .rd_clr_i(rd_clr), .rd_idx_i(bus_addr[2:0]),
        .res_o(res), .ccf_o(ccf), .seq_done_o(seq_done)
    );

    // Read-data multiplexer.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr[3]) begin
            bus_rdata = res[bus_addr[2:0]];
        end else begin
            case (bus_addr)
                A_CTRL:  bus_rdata = {6'b0, fast_clr_q, pwr_en_q};
                A_MODE:  bus_rdata = {mode_q.chan, 1'b0, mode_q.multi, mode_q.scan, mode_q.len8};
                A_STAT:  bus_rdata = {seq_done, 4'b0, seq_idx};
                A_FLAG:  bus_rdata = ccf;
                default: bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/adc_seq_chk.sv
// adc_seq_chk: temporal checks on the sequencer, bound to adc_seq_ctrl.
module adc_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       mode_wr,
    input logic       pwr_en,
    input logic       settled,
    input logic [6:0] mode_bits,
    input logic [7:0] dac_code,
    input logic [7:0] ccf,
    input logic       seq_done,
    input logic [2:0] idx
);
    // R11
    pwr_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_en |-> dac_code == 8'h00);
    // R2
    settle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !settled |-> dac_code == 8'h00);
    // R8
    mode_wr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_wr |=> (ccf == 8'h00 && !seq_done));
    // R4
    short_seq_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_bits[0] |-> ccf[7:4] == 4'h0);
    // R4
    short_seq_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_bits[0] |-> idx < 3'd4);
    // R7
    seq_done_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(seq_done) |-> idx == 3'd0);
endmodule

bind adc_seq_ctrl adc_seq_chk chk_i (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .pwr_en(pwr_en_q),
    .settled(settled), .mode_bits(mode_q), .dac_code(dac_code), .ccf(ccf),
    .seq_done(seq_done), .idx(seq_idx)
);

// File: tb/adc_seq_ctrl_tb_top.sv
// Bench for adc_seq_ctrl: a comparator model over eight analog values, mixed
// directed and seeded random sequences, expected values from bench functions.
module adc_seq_ctrl_tb_top;
    localparam int CLK_PER = 10;
    localparam int SETTLE  = 64;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [3:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       cmp_hi;
    logic [2:0] mux_sel;
    logic [7:0] dac_code;
    logic [7:0] ana [8];
    logic [7:0] exp_res [8];
    int total = 0, bad = 0;

    always #(CLK_PER/2) clk = ~clk;

    assign cmp_hi = (ana[mux_sel] >= dac_code);

    adc_seq_ctrl #(.SAMPLE_CYC(4), .SETTLE_CYC(SETTLE)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cmp_hi(cmp_hi), .mux_sel(mux_sel), .dac_code(dac_code));

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk); bus_addr = a; bus_rd = 1'b1; #1 d = bus_rdata;
        @(negedge clk); bus_rd = 1'b0;
    endtask

    task automatic wait_done(input string req);
        logic [7:0] s;
        for (int n = 0; n < 3000; n++) begin
            rd(4'h2, s);
            if (s[7]) return;
        end
        check(1'b0, req, 0, 1);
    endtask

    function automatic logic [2:0] exp_ch(input int k, input logic [7:0] m);
        if (!m[2]) return m[6:4];
        if (m[0]) return 3'(k);
        return {m[6], 2'(k)};
    endfunction

    task automatic expect_results(input logic [7:0] m, input string req);
        logic [7:0] d;
        int n = m[0] ? 8 : 4;
        for (int k = 0; k < n; k++) exp_res[k] = ana[exp_ch(k, m)];
        for (int k = 0; k < 8; k++) begin
            rd(4'(8 + k), d);
            check(d == exp_res[k], req, d, exp_res[k]);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog act=0 exp=1");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] d, m;
        int seen;
        void'($urandom(32'h5eed_1234));
        for (int k = 0; k < 8; k++) begin ana[k] = 8'($urandom); exp_res[k] = 8'h00; end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state of every register
        for (int a = 0; a < 16; a++) begin
            rd(4'(a), d);
            check(d == 8'h00, "R1 reset reg", d, 0);
        end
        check(dac_code == 8'h00, "R1 dac idle", dac_code, 0);

        // R2: mode write while power off starts nothing
        wr(4'h1, 8'h07);
        repeat (100) @(negedge clk);
        rd(4'h3, d); check(d == 8'h00, "R2 no start when off", d, 0);

        // R2: settle window, then 8-conversion group (R3 R5 R6)
        wr(4'h0, 8'h01);
        wr(4'h1, 8'h05);
        seen = 0;
        for (int c = 0; c < SETTLE - 4; c++) begin
            @(negedge clk); if (dac_code != 8'h00) seen++;
        end
        check(seen == 0, "R2 settle quiet", seen, 0);
        wait_done("R5 done timeout");
        expect_results(8'h05, "R3 R5 result");
        rd(4'h3, d); check(d == 8'hFF, "R5 flags", d, 8'hFF);

        // R4 R6 R8: random sequences with normal flag clearing
        for (int it = 0; it < 10; it++) begin
            for (int k = 0; k < 8; k++) ana[k] = 8'($urandom);
            m = 8'($urandom) & 8'hF5;     // scan off, bit 3 off
            if (it == 0) m = 8'hC4;       // four-group, upper half, bit 7 set
            if (it == 1) m = 8'h34;       // four-group, lower half
            wr(4'h1, m);
            rd(4'h3, d); check(d == 8'h00, "R8 mode write clears", d, 0);
            wait_done("R4 done timeout");
            expect_results(m, "R4 R6 result");
            rd(4'h3, d);
            check(d == (m[0] ? 8'hFF : 8'h0F), "R4 flags", d, m[0] ? 8'hFF : 8'h0F);
            rd(4'h2, d); check(d == 8'h80, "R8 status kept after reads", d, 8'h80);
        end

        // R9: fast clear, single channel 5 four times
        wr(4'h0, 8'h03);
        wr(4'h1, 8'h50);
        wait_done("R9 done timeout");
        rd(4'hA, d); check(d == ana[5], "R6 single channel", d, ana[5]);
        rd(4'h3, d); check(d == 8'h0B, "R9 read clears flag", d, 8'h0B);
        rd(4'h2, d); check(d[7] == 1'b0, "R9 read clears seq flag", d, 0);
        wr(4'h0, 8'h01);

        // R10: abort mid-sequence and restart from conversion 0
        wr(4'h1, 8'h05);
        for (int n = 0; n < 500; n++) begin
            rd(4'h2, d); if (d[2:0] >= 3'd2) break;
        end
        for (int k = 0; k < 8; k++) ana[k] = ~ana[k];
        wr(4'h1, 8'h05);
        rd(4'h2, d); check(d == 8'h00, "R10 counter restarts", d, 0);
        wait_done("R10 done timeout");
        expect_results(8'h05, "R10 result");

        // R7: continuous scan picks up new inputs
        wr(4'h1, 8'h07);
        wait_done("R7 done timeout");
        for (int k = 0; k < 8; k++) ana[k] = 8'($urandom);
        repeat (400) @(negedge clk);
        for (int k = 0; k < 8; k++) exp_res[k] = ana[k];
        for (int k = 0; k < 8; k++) begin
            rd(4'(8 + k), d); check(d == exp_res[k], "R7 scan result", d, exp_res[k]);
        end
        seen = 0;
        for (int c = 0; c < 40; c++) begin @(negedge clk); if (dac_code != 0) seen++; end
        check(seen > 0, "R7 still running", seen, 1);

        // R11: power off stops everything
        wr(4'h0, 8'h00);
        for (int k = 0; k < 8; k++) ana[k] = ~ana[k];
        seen = 0;
        for (int c = 0; c < 300; c++) begin @(negedge clk); if (dac_code != 0) seen++; end
        check(seen == 0, "R11 quiet after off", seen, 0);
        for (int k = 0; k < 8; k++) begin
            rd(4'(8 + k), d); check(d == exp_res[k], "R11 results frozen", d, exp_res[k]);
        end

        // R12: readback of ctrl and mode
        wr(4'h0, 8'hFE);
        rd(4'h0, d); check(d == 8'h02, "R12 ctrl readback", d, 8'h02);
        wr(4'h1, 8'hBE);
        rd(4'h1, d); check(d == 8'hB6, "R12 mode readback", d, 8'hB6);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule